// File: doc/BRIEF.md
# Compare-Match Period Trigger

The block keeps a 16-bit up-counter that steps once for every cycle in which the timer clock enable is high, and a 16-bit compare register that software loads one byte at a time. When the counter and the compare register hold the same value, the block raises a trigger pulse one system clock long. That pulse is meant for a downstream consumer, such as a conversion start. The block drives no output pin.

The counter is not cleared at the match. It keeps the matching value until the next timer clock enable and drops to zero on that enable. A compare value of N therefore gives the count sequence 0, 1, ..., N, 0 and a period of N+1 timer clocks. The compare register acts as a programmable 16-bit period. The counter and the compare register can both be read at the ports at any time.

Top module: `period_trigger`

## Requirements
- R1: A synchronous active-high reset sets the counter to 0, the compare register to 0 and the trigger to 0.
- R2: In a cycle with the enable high and counter different from compare, the counter advances by one, wrapping 0xFFFF to 0. With the enable low it holds its value.
- R3: In a cycle with the enable high and counter equal to compare (the compare value before any write in that cycle), the counter goes to 0. Between enables it keeps the matching value.
- R4: With compare N and the enable high in every cycle, the counter runs 0..N and returns to 0, so one period is N+1 enables.
- R5: The trigger is high in the very cycle in which the counter output first shows a value equal to the compare output, for one system clock.
- R6: While counter and compare stay equal and no enable or write arrives, the trigger does not repeat.
- R7: With compare 0, each enable produces one trigger pulse while the counter stays at 0.
- R8: A write with lane select 0 loads data into compare bits 7:0. A write with select 1 loads bits 15:8. The other byte keeps its value, and the new value shows in the cycle after the write.
- R9: If compare is set below the current counter value, the counter keeps counting, wraps at 0xFFFF to 0 and triggers when it later reaches the compare value.
- R10: A write that makes compare equal to a counter that is already standing still fires the trigger in the cycle in which the new compare value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_tick | input | 1 | Timer clock enable, one count per high cycle |
| wr_en | input | 1 | Compare byte write strobe |
| wr_sel | input | 1 | Byte lane select (0 low byte, 1 high byte) |
| wr_data | input | 8 | Byte written to the selected lane |
| timer_val | output | 16 | Current counter value |
| period_val | output | 16 | Current compare value |
| event_trig | output | 1 | One-clock trigger pulse on a match |

## Verification
The bench builds the block with its default parameters: a 16-bit counter made of two 8-bit lanes. With these values both byte lanes can be written separately. The enable is held high for long stretches so that one full 65536-count wrap fits in the run, which covers the case of a compare value written below the counter. Short periods, a zero compare value, sparse enables and writes that land exactly on a stopped counter cover the pulse and reload timing.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;

    // What the counter does on a given cycle
    typedef enum logic [1:0] {
        TMR_HOLD  = 2'd0,
        TMR_STEP  = 2'd1,
        TMR_CLEAR = 2'd2
    } tmr_op_e;

    function automatic int lane_count(input int cnt_w, input int byte_w);
        return cnt_w / byte_w;
    endfunction

    function automatic int sel_bits(input int lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

endpackage

// File: rtl/pt_cmp_reg.sv
`timescale 1ns/1ps
module pt_cmp_reg #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cmp_q,
    output logic [CNT_W-1:0]  cmp_d
);
    localparam int LANES = pt_pkg::lane_count(CNT_W, BYTE_W);

    // Each byte lane either takes the written byte or keeps its old value
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic hit;
        assign hit = wr_en && (wr_sel == SEL_W'(i));
        assign cmp_d[i*BYTE_W +: BYTE_W] = hit ? wr_data : cmp_q[i*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) cmp_q <= '0;
        else     cmp_q <= cmp_d;
    end
endmodule

// File: rtl/pt_timer.sv
`timescale 1ns/1ps
module pt_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_q,
    output logic [CNT_W-1:0] tmr_q,
    output logic [CNT_W-1:0] tmr_d
);
    import pt_pkg::*;

    tmr_op_e op;

    // The clear waits for the next enable after the counter reaches the match value
    always_comb begin
        if (!tick)               op = TMR_HOLD;
        else if (tmr_q == cmp_q) op = TMR_CLEAR;
        else                     op = TMR_STEP;
    end

    always_comb begin
        unique case (op)
            TMR_STEP:  tmr_d = tmr_q + 1'b1;
            TMR_CLEAR: tmr_d = '0;
            default:   tmr_d = tmr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end
endmodule

// File: rtl/pt_trig.sv
`timescale 1ns/1ps
module pt_trig #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] tmr_q,
    input  logic [CNT_W-1:0] cmp_q,
    input  logic [CNT_W-1:0] tmr_d,
    input  logic [CNT_W-1:0] cmp_d,
    output logic             trig_q
);
    logic match_now;
    logic match_next;
    logic fresh;

    assign match_now  = (tmr_q == cmp_q);
    assign match_next = (tmr_d == cmp_d);
    // A new match is one reached by a count step, or one that did not exist before
    assign fresh      = tick || !match_now;

    // The pulse is registered together with the values that cause it
    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= match_next && fresh;
    end
endmodule

// File: rtl/period_trigger.sv
`timescale 1ns/1ps
module period_trigger #(
    parameter  int CNT_W  = 16,
    parameter  int BYTE_W = 8,
    localparam int LANES  = pt_pkg::lane_count(CNT_W, BYTE_W),
    localparam int SEL_W  = pt_pkg::sel_bits(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_tick,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  timer_val,
    output logic [CNT_W-1:0]  period_val,
    output logic              event_trig
);
    logic [CNT_W-1:0] cmp_q, cmp_d;
    logic [CNT_W-1:0] tmr_q, tmr_d;

    pt_cmp_reg #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cmp_q   (cmp_q),
        .cmp_d   (cmp_d)
    );

    pt_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .tick  (tmr_tick),
        .cmp_q (cmp_q),
        .tmr_q (tmr_q),
        .tmr_d (tmr_d)
    );

    pt_trig #(.CNT_W(CNT_W)) u_trig (
        .clk    (clk),
        .rst    (rst),
        .tick   (tmr_tick),
        .tmr_q  (tmr_q),
        .cmp_q  (cmp_q),
        .tmr_d  (tmr_d),
        .cmp_d  (cmp_d),
        .trig_q (event_trig)
    );

    assign timer_val  = tmr_q;
    assign period_val = cmp_q;
endmodule

// File: rtl/period_trigger_chk.sv
`timescale 1ns/1ps
module period_trigger_chk #(
    parameter  int CNT_W  = 16,
    parameter  int BYTE_W = 8,
    localparam int LANES  = pt_pkg::lane_count(CNT_W, BYTE_W),
    localparam int SEL_W  = pt_pkg::sel_bits(LANES)
) (
    input logic              clk,
    input logic              rst,
    input logic              tmr_tick,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic [CNT_W-1:0]  timer_val,
    input logic [CNT_W-1:0]  period_val,
    input logic              event_trig
);
    // R1
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (timer_val == '0 && period_val == '0 && !event_trig));

    // R2
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tmr_tick && timer_val != period_val) |=> (timer_val == CNT_W'($past(timer_val) + 1'b1)));

    // R2
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tmr_tick |=> $stable(timer_val));

    // R3
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (tmr_tick && timer_val == period_val) |=> (timer_val == '0));

    // R5
    p_trig_on_match_r5: assert property (@(posedge clk) disable iff (rst)
        event_trig |-> (timer_val == period_val));

    // R5
    p_trig_on_step_r5: assert property (@(posedge clk) disable iff (rst)
        (tmr_tick && !wr_en && timer_val != period_val
         && CNT_W'(timer_val + 1'b1) == period_val) |=> event_trig);

    // R6
    p_no_repeat_r6: assert property (@(posedge clk) disable iff (rst)
        (event_trig && !tmr_tick && !wr_en) |=> !event_trig);

    // R8
    p_low_lane_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == '0) |=> (period_val[BYTE_W-1:0] == $past(wr_data)));
endmodule

bind period_trigger period_trigger_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/period_trigger_bench.sv
`timescale 1ns/1ps
module period_trigger_bench;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 1;

    typedef struct {
        logic [CNT_W-1:0] tmr;
        logic [CNT_W-1:0] cmp;
        logic             trig;
        string            tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tmr_tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [SEL_W-1:0]  wr_sel = '0;
    logic [BYTE_W-1:0] wr_data = '0;
    logic [CNT_W-1:0]  timer_val;
    logic [CNT_W-1:0]  period_val;
    logic              event_trig;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];
    exp_t got;

    // Reference state, kept from the requirements
    logic [CNT_W-1:0] m_tmr = '0;
    logic [CNT_W-1:0] m_cmp = '0;

    always #2.5 clk = ~clk;

    period_trigger #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_period_trigger (
        .clk        (clk),
        .rst        (rst),
        .tmr_tick   (tmr_tick),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .timer_val  (timer_val),
        .period_val (period_val),
        .event_trig (event_trig)
    );

    // Driver: apply one cycle of stimulus and push the expected outcome
    task automatic step(input logic tk, input logic we, input logic [SEL_W-1:0] sel,
                        input logic [BYTE_W-1:0] d, input string tag);
        exp_t e;
        logic was_eq;
        logic [CNT_W-1:0] t_n, c_n;
        @(negedge clk);
        tmr_tick = tk;
        wr_en    = we;
        wr_sel   = sel;
        wr_data  = d;
        was_eq = (m_tmr == m_cmp);
        t_n = m_tmr;
        if (tk) t_n = was_eq ? '0 : CNT_W'(m_tmr + 1'b1);       // R2, R3
        c_n = m_cmp;
        if (we) c_n[int'(sel)*BYTE_W +: BYTE_W] = d;              // R8
        e.tmr  = t_n;
        e.cmp  = c_n;
        e.trig = (t_n == c_n) && (tk || !was_eq);                 // R5, R6, R7, R10
        e.tag  = tag;
        sb_q.push_back(e);
        m_tmr = t_n;
        m_cmp = c_n;
    endtask

    // Monitor: compare after each active edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            got = sb_q.pop_front();
            n_checks++;
            if (timer_val !== got.tmr || period_val !== got.cmp || event_trig !== got.trig) begin
                n_fails++;
                $display("FAIL %s: timer=%h cmp=%h trig=%b expected timer=%h cmp=%h trig=%b",
                         got.tag, timer_val, period_val, event_trig, got.tmr, got.cmp, got.trig);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        step(0, 0, 0, 8'h00, "R1");
        step(0, 0, 0, 8'h00, "R1");
        // R7: compare 0, a pulse on each enable, with idle gaps
        for (int i = 0; i < 8; i++) step((i % 2) == 0, 0, 0, 8'h00, "R7");
        // R8: byte lanes written separately
        step(0, 1, 0, 8'h04, "R8");
        step(0, 1, 1, 8'h12, "R8");
        step(0, 0, 0, 8'h00, "R8");
        step(0, 1, 1, 8'h00, "R8");
        // R4: period of compare+1 with the enable held high
        for (int i = 0; i < 16; i++) step(1, 0, 0, 8'h00, "R4");
        // R2: enable low holds the counter
        for (int i = 0; i < 4; i++) step(0, 0, 0, 8'h00, "R2");
        // R3 and R6: sparse enables, counter rests on the match value
        for (int i = 0; i < 36; i++) step((i % 3) == 0, 0, 0, 8'h00, "R6");
        for (int i = 0; i < 10; i++) step(1, 0, 0, 8'h00, "R3");
        // R10: stop at 2, then write compare to 2
        for (int i = 0; i < 10 && m_tmr != 16'h0002; i++) step(1, 0, 0, 8'h00, "R5");
        step(0, 1, 0, 8'h02, "R10");
        step(0, 1, 0, 8'h02, "R10");
        step(0, 0, 0, 8'h00, "R6");
        // R9: compare written below the counter forces a full wrap
        step(0, 1, 1, 8'h01, "R9");
        for (int i = 0; i < 400 && m_tmr != 16'h0020; i++) step(1, 0, 0, 8'h00, "R9");
        step(0, 1, 0, 8'h10, "R9");
        step(0, 1, 1, 8'h00, "R9");
        for (int i = 0; i < 70000 && m_tmr != 16'h0010; i++) step(1, 0, 0, 8'h00, "R9");
        for (int i = 0; i < 20; i++) step(1, 0, 0, 8'h00, "R9");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule